// File: doc/BRIEF.md
# Variable-Length Serial Configuration Register Port

This block is a three-wire serial slave that fronts a bank of configuration registers, each address having its own width taken from a parameter table. A controller pulls the select strobe low, clocks out a 4-bit address (MSB first) and a direction bit on rising serial-clock edges, then moves a data field of any length MSB first. The strobe going high ends the message.

Writes go through a single staging copy, loaded from the addressed register when the direction bit arrives. Received bits overwrite the staging copy starting at the register MSB. A message shorter than the register leaves the low bits as they were and is committed when the strobe rises. A message longer than the register is committed on the first surplus clock edge, and later bits are dropped. Reads drive the register out MSB first on a split data line (value plus output enable); pad tristate handling lies outside the block. All serial inputs are synchronised to the system clock and acted upon on detected edges, so the serial clock must be several system clocks slower.

Top module: `cfg_serial_port`

## Requirements
- R1: A message is framed while `ser_sel_n` is low: the first four `ser_clk` rising edges shift in the address MSB first, the fifth samples the direction bit (1 = write, 0 = read), and each later edge carries one data bit, MSB first; a falling `ser_sel_n` restarts framing at the first address bit.
- R2: A write of L data bits to a register of width W with L < W replaces bits W-1 down to W-L with the bits in arrival order and keeps bits W-L-1..0; L = W replaces the whole register.
- R3: Data bits after the first W are ignored, and bits of a register slot at positions W and above always read zero on `cfg_regs`.
- R4: A write with L <= W leaves the register unchanged while `ser_sel_n` is still low and takes effect only after `ser_sel_n` rises.
- R5: A write with L > W takes effect after the (W+1)-th data edge, before `ser_sel_n` rises.
- R6: A message to an address whose table width is 0, or a message whose strobe rises before the direction bit, changes no register; a read of such an address never asserts `ser_doe`.
- R7: For a read of a mapped register, `ser_doe` rises after the direction-bit edge; before data edge k (k = 0, 1, ...) `ser_dout` shows register bit W-1-k, and 0 once k >= W.
- R8: `ser_doe` is low whenever the synchronised strobe is high, and drops when `ser_sel_n` rises.
- R9: After reset every register slot is zero and `ser_doe` is low.
- R10: A commit updates the whole addressed register in one system-clock cycle, and at most one register slot changes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Select/latch strobe, low for the whole message |
| ser_clk | input | 1 | Serial clock, bits taken on its rising edge |
| ser_din | input | 1 | Serial data from the controller |
| ser_dout | output | 1 | Serial read data |
| ser_doe | output | 1 | Output enable for the data line during reads |
| cfg_regs | output | 2^ADDR_W * DW | All register slots, slot a at bits a*DW +: DW |

## Verification
The checker watches every cycle for the structural rules: register changes happen only right after a commit pulse and touch one slot, bits above each slot's width stay zero, and the output enable is raised only by a serial clock edge and never while the strobe is high. Whether the right bits land in the right positions, whether a short write waits for the strobe and a long one does not, and whether read data appears MSB first and pads with zeros, all depend on message content. Only the bench's sweep over every address with lengths around each width can show them.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_RWBIT = 2'd2,
    PH_DATA  = 2'd3
  } ser_phase_t;

  localparam int unsigned LANE_STRB = 0;
  localparam int unsigned LANE_SCLK = 1;
  localparam int unsigned LANE_SDI  = 2;
  localparam int unsigned LANES     = 3;
endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync #(
  parameter int unsigned N = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] now,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      lvl <= RST_VAL;
    end else begin
      pipe[0] <= d_in;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      lvl <= pipe[STAGES-1];
    end
  end

  assign now  = pipe[STAGES-1];
  assign rise = now & ~lvl;
  assign fall = ~now & lvl;
endmodule

// File: rtl/cfg_serial_frame.sv
module cfg_serial_frame
  import cfg_serial_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned WID_W = 6,
  parameter logic [(1<<ADDR_W)*WID_W-1:0] REG_WIDTHS = '0,
  localparam int unsigned CNT_W = $clog2(DW + 2),
  localparam int unsigned ACW = $clog2(ADDR_W + 1),
  localparam int unsigned PW = (DW > 1) ? $clog2(DW) : 1,
  localparam int unsigned CW = ((WID_W > CNT_W) ? WID_W : CNT_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_rise,
  input  logic              strb_fall,
  input  logic              sclk_rise,
  input  logic              sdi,
  output logic [ADDR_W-1:0] addr,
  output logic              stage_load,
  output logic              bit_we,
  output logic [PW-1:0]     bit_pos,
  output logic              commit,
  output logic              rd_en,
  output logic              rd_valid
);
  ser_phase_t        phase_q;
  logic [ACW-1:0]    acnt_q;
  logic [CNT_W-1:0]  dcnt_q;
  logic [WID_W-1:0]  wid_q;
  logic [WID_W-1:0]  wid_lookup;
  logic              wr_q;
  logic              done_q;
  logic              edge_ok;
  logic              in_write;
  logic [CW-1:0]     pos_full;

  assign wid_lookup = REG_WIDTHS[addr*WID_W +: WID_W];
  assign edge_ok    = sclk_rise && !strb_rise && !strb_fall;
  assign in_write   = (phase_q == PH_DATA) && wr_q && (wid_q != '0) && !done_q;
  assign pos_full   = CW'(wid_q) - CW'(dcnt_q) - CW'(1);
  assign bit_pos    = pos_full[PW-1:0];
  assign rd_valid   = CW'(dcnt_q) < CW'(wid_q);

  always_comb begin
    stage_load = edge_ok && (phase_q == PH_RWBIT) && sdi && (wid_lookup != '0);
    bit_we     = edge_ok && in_write && (CW'(dcnt_q) < CW'(wid_q));
    commit     = (strb_rise && in_write) ||
                 (edge_ok && in_write && (CW'(dcnt_q) == CW'(wid_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acnt_q  <= '0;
      dcnt_q  <= '0;
      wid_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      addr    <= '0;
      rd_en   <= 1'b0;
    end else if (strb_fall) begin
      phase_q <= PH_ADDR;
      acnt_q  <= '0;
      dcnt_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      rd_en   <= 1'b0;
    end else if (strb_rise) begin
      phase_q <= PH_IDLE;
      rd_en   <= 1'b0;
    end else if (sclk_rise) begin
      case (phase_q)
        PH_ADDR: begin
          addr   <= (addr << 1) | ADDR_W'(sdi);
          acnt_q <= acnt_q + ACW'(1);
          if (acnt_q == ACW'(ADDR_W - 1)) phase_q <= PH_RWBIT;
        end
        PH_RWBIT: begin
          wr_q    <= sdi;
          wid_q   <= wid_lookup;
          dcnt_q  <= '0;
          phase_q <= PH_DATA;
          rd_en   <= !sdi && (wid_lookup != '0);
        end
        PH_DATA: begin
          if (dcnt_q != CNT_W'(DW + 1)) dcnt_q <= dcnt_q + CNT_W'(1);
          if (commit) done_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned WID_W = 6,
  parameter logic [(1<<ADDR_W)*WID_W-1:0] REG_WIDTHS = '0,
  localparam int unsigned NREG = 1 << ADDR_W,
  localparam int unsigned PW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               stage_load,
  input  logic               bit_we,
  input  logic [PW-1:0]      bit_pos,
  input  logic               bit_val,
  input  logic               commit,
  input  logic               rd_en,
  input  logic               rd_valid,
  output logic               sdo,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] staging_q;
  logic [DW-1:0] cur;

  assign cur = regs_flat[addr*DW +: DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          staging_q <= '0;
    else if (stage_load) staging_q <= cur;
    else if (bit_we)     staging_q[bit_pos] <= bit_val;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam int unsigned W = REG_WIDTHS[g*WID_W +: WID_W];
    localparam logic [DW-1:0] MASK = (W >= DW) ? {DW{1'b1}} : ((DW'(1) << W) - DW'(1));
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (commit && (addr == ADDR_W'(g))) q <= staging_q & MASK;
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  assign sdo = rd_en && rd_valid && cur[bit_pos];
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned WID_W = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [(1<<ADDR_W)*WID_W-1:0] REG_WIDTHS = {
    6'd0, 6'd2, 6'd31, 6'd7, 6'd20, 6'd3, 6'd0, 6'd5,
    6'd12, 6'd0, 6'd24, 6'd1, 6'd32, 6'd16, 6'd8, 6'd10},
  localparam int unsigned NREG = 1 << ADDR_W,
  localparam int unsigned PW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_sel_n,
  input  logic               ser_clk,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic               ser_doe,
  output logic [NREG*DW-1:0] cfg_regs
);
  logic [LANES-1:0] s_now, s_lvl, s_rise, s_fall;
  logic strb_lvl, strb_rise, strb_fall, sclk_rise, sdi_now;
  logic [ADDR_W-1:0] addr;
  logic stage_load, bit_we, commit, rd_valid;
  logic [PW-1:0] bit_pos;

  cfg_serial_sync #(
    .N(LANES), .STAGES(SYNC_STAGES), .RST_VAL(LANES'(1) << LANE_STRB)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({ser_din, ser_clk, ser_sel_n}),
    .now(s_now), .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign strb_lvl  = s_lvl[LANE_STRB];
  assign strb_rise = s_rise[LANE_STRB];
  assign strb_fall = s_fall[LANE_STRB];
  assign sclk_rise = s_rise[LANE_SCLK];
  assign sdi_now   = s_now[LANE_SDI];

  cfg_serial_frame #(
    .ADDR_W(ADDR_W), .DW(DW), .WID_W(WID_W), .REG_WIDTHS(REG_WIDTHS)
  ) u_frame (
    .clk(clk), .rst_n(rst_n),
    .strb_rise(strb_rise), .strb_fall(strb_fall), .sclk_rise(sclk_rise),
    .sdi(sdi_now), .addr(addr), .stage_load(stage_load), .bit_we(bit_we),
    .bit_pos(bit_pos), .commit(commit), .rd_en(ser_doe), .rd_valid(rd_valid)
  );

  cfg_serial_bank #(
    .ADDR_W(ADDR_W), .DW(DW), .WID_W(WID_W), .REG_WIDTHS(REG_WIDTHS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .stage_load(stage_load),
    .bit_we(bit_we), .bit_pos(bit_pos), .bit_val(sdi_now), .commit(commit),
    .rd_en(ser_doe), .rd_valid(rd_valid), .sdo(ser_dout), .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW = 32,
  parameter int unsigned WID_W = 6,
  parameter logic [(1<<ADDR_W)*WID_W-1:0] REG_WIDTHS = '0,
  localparam int unsigned NREG = 1 << ADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREG*DW-1:0] cfg_regs,
  input logic               ser_doe,
  input logic               strb_lvl,
  input logic               sclk_rise,
  input logic               commit
);
  logic [NREG*DW-1:0] prev_q;
  logic [NREG-1:0]    chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cfg_regs;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_c
    localparam int unsigned W = REG_WIDTHS[g*WID_W +: WID_W];
    localparam logic [DW-1:0] MASK = (W >= DW) ? {DW{1'b1}} : ((DW'(1) << W) - DW'(1));
    assign chg[g] = cfg_regs[g*DW +: DW] != prev_q[g*DW +: DW];
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_regs[g*DW +: DW] & ~MASK) == '0); // R3
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg)); // R10
  AST_CHANGE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> $past(commit)); // R4
  AST_OE_ON_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_doe) |-> $past(sclk_rise)); // R7
  AST_OE_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ser_doe |-> !strb_lvl); // R8
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .WID_W(WID_W), .REG_WIDTHS(REG_WIDTHS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_regs(cfg_regs), .ser_doe(ser_doe),
  .strb_lvl(strb_lvl), .sclk_rise(sclk_rise), .commit(commit)
);

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  localparam int H = 4;
  localparam logic [16*6-1:0] WT = {
    6'd0, 6'd2, 6'd31, 6'd7, 6'd20, 6'd3, 6'd0, 6'd5,
    6'd12, 6'd0, 6'd24, 6'd1, 6'd32, 6'd16, 6'd8, 6'd10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic dout, doe;
  logic [16*32-1:0] regs;
  logic [31:0] model [16];
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  cfg_serial_port #(.REG_WIDTHS(WT)) u_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(sel_n), .ser_clk(sclk),
    .ser_din(sdi), .ser_dout(dout), .ser_doe(doe), .cfg_regs(regs));

  function automatic int wt(int a);
    return int'(WT[a*6 +: 6]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; sclk = 1'b0; wait_clk(H);
    sclk = 1'b1; wait_clk(H);
  endtask

  task automatic start_msg();
    sclk = 1'b0; sel_n = 1'b0; wait_clk(H);
  endtask

  task automatic end_msg();
    sclk = 1'b0; wait_clk(H);
    sel_n = 1'b1; wait_clk(8);
  endtask

  task automatic send_addr(input int a);
    for (int i = 3; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic bank_check(input string req);
    @(negedge clk);
    for (int a = 0; a < 16; a++)
      chk(regs[a*32 +: 32] == model[a], req, 64'(regs[a*32 +: 32]), 64'(model[a]));
  endtask

  task automatic do_write(input int a, input int len, input logic [63:0] v);
    int w = wt(a);
    logic [31:0] nv = model[a];
    for (int i = 0; i < len && i < w; i++) nv[w-1-i] = v[63-i];
    start_msg();
    send_addr(a);
    send_bit(1'b1);
    for (int i = 0; i < len; i++) send_bit(v[63-i]);
    wait_clk(2);
    @(negedge clk);
    if (w != 0 && len > w)
      chk(regs[a*32 +: 32] == nv, "R5 long write commits before strobe", 64'(regs[a*32 +: 32]), 64'(nv));
    else
      chk(regs[a*32 +: 32] == model[a], "R4 no commit while strobe low", 64'(regs[a*32 +: 32]), 64'(model[a]));
    end_msg();
    if (w != 0) model[a] = nv;
    @(negedge clk);
    if (w == 0)
      bank_check("R6 unmapped write");
    else if (len > w)
      chk(regs[a*32 +: 32] == model[a], "R3 surplus ignored", 64'(regs[a*32 +: 32]), 64'(model[a]));
    else
      chk(regs[a*32 +: 32] == model[a], "R2 partial merge", 64'(regs[a*32 +: 32]), 64'(model[a]));
  endtask

  task automatic do_read(input int a);
    int w = wt(a);
    start_msg();
    send_addr(a);
    send_bit(1'b0);
    for (int k = 0; k < w + 2; k++) begin
      sclk = 1'b0; wait_clk(H);
      @(negedge clk);
      if (w == 0) chk(doe == 1'b0, "R6 unmapped read not driven", 64'(doe), 64'(0));
      else begin
        logic e = (k < w) ? model[a][w-1-k] : 1'b0;
        chk(doe == 1'b1, "R7 enable during read", 64'(doe), 64'(1));
        chk(dout == e, "R7 read bit", 64'(dout), 64'(e));
      end
      sclk = 1'b1; wait_clk(H);
    end
    end_msg();
    @(negedge clk);
    chk(doe == 1'b0, "R8 enable released", 64'(doe), 64'(0));
  endtask

  initial begin
    wait_clk(200000);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int a = 0; a < 16; a++) model[a] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    bank_check("R9 reset state");
    chk(doe == 1'b0, "R9 reset enable", 64'(doe), 64'(0));

    // R6: aborted messages before the direction bit
    start_msg(); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); end_msg();
    bank_check("R6 abort after three address bits");
    start_msg(); send_addr(0); end_msg();
    bank_check("R6 abort after address");
    // R1: framing restarts after an aborted message
    do_write(0, 10, 64'hA5C0_0000_0000_0000);
    bank_check("R1 framing after abort");

    for (int a = 0; a < 16; a++) begin
      int w = wt(a);
      int lens [8];
      lens = '{0, 1, 2, w - 1, w, w + 1, w + 2, 33};
      for (int j = 0; j < 8; j++) begin
        int len = (lens[j] < 0) ? 0 : lens[j];
        logic [63:0] v = 64'h9E37_79B9_7F4A_7C15 * 64'(a * 40 + j + 7);
        do_write(a, len, v);
        do_read(a);
      end
      bank_check("R10 other slots untouched");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule